// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers up to three banks of 32 interrupt request lines and presents them to a processor as two outputs: a normal request and a fast request. Each line has its own 7-bit configuration word that gives it a 5-bit priority, chooses edge or level sensitivity and routes it to one of the two outputs. Requests pass through a two-stage synchroniser before their edges are detected. They then land in a per-bank pending register, are filtered by a per-bank mask, and are resolved by priority into a single winning line code for each output.

Each output follows an agreement handshake. Once software has armed an output, that output is raised the first time a candidate exists, and the winning line code is captured at that moment. The output then stays high, and its code stays the same, until software re-arms it through the control register. Reading a winner code acknowledges an edge-type winner, which clears its pending bit. Clearing pending bits by a write cannot drop a level line whose input is still asserted. The register port is a plain one-cycle strobe interface: writes take effect at the next clock edge and read data is combinational while the read strobe is high. There is no back-pressure, so no valid/ready handshake is used.

Top module: `banked_intc`

## Requirements
- R1: After reset every mask bit reads 1, every pending bit and every line configuration word read 0, both outputs are low, and both outputs are armed.
- R2: The configuration word of line n of a bank is at offset 0x1C+4n. Bits [6:2] hold the priority, bit 1 selects level sensitivity (1) or edge sensitivity (0), and bit 0 routes the line to the fast output (1) or the normal output (0). Writes keep bits [6:0] and the word reads back with zeros above bit 6.
- R3: An edge line becomes pending only on a low-to-high transition of its synchronised input. An input that stays high does not make the line pending again after it has been cleared.
- R4: A level line is pending whenever its synchronised input is high. A write to the pending register cannot clear it while the input stays high, and the pending bit clears when the input falls.
- R5: A write to the pending register (offset 0x00) ANDs the bank's pending bits with the written value. The register reads back the pending bits.
- R6: A write to the software-set register (offset 0x08) sets the pending bits of the lines given by the written 1 bits.
- R7: A candidate is a pending, unmasked line that is routed to the output in question. Among the candidates, the lowest priority value wins. When two candidates have equal priority, the higher line number wins. The global line number is 32 × bank + bit.
- R8: An armed output rises on the cycle after a candidate exists, and rising disarms it. The output then stays high and its captured code stays fixed until a write to the control register (offset 0x18, bit 0 for the normal output, bit 1 for the fast output). That write lowers the output and re-arms it, so the output rises again on the following cycle if a candidate exists.
- R9: A read of offset 0x10 (normal) or 0x14 (fast) in bank 0 returns the code captured when that output last rose. If the captured line is edge-sensitive, the read clears its pending bit. A level line is left pending.
- R10: The mask register (offset 0x04, 1 = masked) is read/write. A masked line never makes an output rise, and unmasking a pending line does make an armed output rise.
- R11: Address bits [9:8] select the bank and bits [7:0] select the offset. A bank number of NUM_BANKS or higher, a non-word-aligned offset, an unused offset, or a code or control offset outside bank 0 reads as zero and ignores writes.
- R12: An input that rises next to an armed output, on an unmasked edge line, raises that output exactly four clock edges after the input changes. The four edges are two synchroniser stages, the pending register and the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_BANKS*32 | Asynchronous request inputs, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads of the code registers have side effects) |
| addr | input | 10 | Register address: bank in [9:8], byte offset in [7:0] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high, zero otherwise |
| out_norm | output | 1 | Normal interrupt output |
| out_fast | output | 1 | Fast interrupt output |

## Verification
The hardest situations to reach are the ones where the pending state must survive or ignore an action while an input is held steady. One is a level line whose input stays high across a pending-clear write and across a code read. Another is an edge line whose input is still high after its acknowledge and must not become pending again. The bench holds such inputs through the synchroniser latency and then observes the pending register through the bus. It then drops and re-raises the input to show that edge detection has re-armed. A second hard situation is a new request that arrives while an output is already raised. The bench shows that the captured code does not move until the control write, and that the new winner appears on the cycle after re-arming.

// File: rtl/bintc_pkg.sv
package bintc_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int PRIO_W         = 5;
  localparam int BUS_AW         = 10;
  localparam int MAX_BANKS      = 4;

  localparam logic [7:0] OFF_PEND   = 8'h00;
  localparam logic [7:0] OFF_MASK   = 8'h04;
  localparam logic [7:0] OFF_SWSET  = 8'h08;
  localparam logic [7:0] OFF_CODE_N = 8'h10;
  localparam logic [7:0] OFF_CODE_F = 8'h14;
  localparam logic [7:0] OFF_CTRL   = 8'h18;
  localparam logic [7:0] OFF_CFG_LO = 8'h1C;
  localparam logic [7:0] OFF_CFG_HI = 8'h98;

  // matches the register word layout: [6:2] prio, [1] level, [0] fast
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              level;
    logic              fast;
  } line_cfg_t;
endpackage

// File: rtl/bintc_sync.sv
module bintc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign sync = s2_q;
  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;
endmodule

// File: rtl/bintc_bank.sv
module bintc_bank
  import bintc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LINES_PER_BANK-1:0]     sync,
  input  logic [LINES_PER_BANK-1:0]     rise,
  input  logic [LINES_PER_BANK-1:0]     fall,
  input  logic                          pend_wr,
  input  logic                          mask_wr,
  input  logic                          swset_wr,
  input  logic                          cfg_wr,
  input  logic [$clog2(LINES_PER_BANK)-1:0] cfg_idx,
  input  logic [31:0]                   wdata,
  input  logic [LINES_PER_BANK-1:0]     ack,
  output logic [LINES_PER_BANK-1:0]     pend_o,
  output logic [LINES_PER_BANK-1:0]     mask_o,
  output logic [LINES_PER_BANK-1:0]     lvl_o,
  output logic [LINES_PER_BANK-1:0]     fast_o,
  output line_cfg_t [LINES_PER_BANK-1:0] cfg_o
);
  localparam int LB = LINES_PER_BANK;
  localparam int CW = $bits(line_cfg_t);

  line_cfg_t [LB-1:0] cfg_q;
  logic [LB-1:0] pend_q, pend_d, mask_q;

  for (genvar i = 0; i < LB; i++) begin : g_fields
    assign lvl_o[i]  = cfg_q[i].level;
    assign fast_o[i] = cfg_q[i].fast;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q[cfg_idx] <= line_cfg_t'(wdata[CW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= wdata[LB-1:0];
  end

  // clears first, then sets, so a fresh request in the same cycle is kept
  always_comb begin
    pend_d = pend_q;
    if (pend_wr) pend_d = pend_d & (wdata[LB-1:0] | (sync & lvl_o));
    pend_d = pend_d & ~(fall & lvl_o);
    pend_d = pend_d & ~(ack & ~lvl_o);
    pend_d = pend_d | (rise & ~lvl_o) | (sync & lvl_o);
    if (swset_wr) pend_d = pend_d | wdata[LB-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign cfg_o  = cfg_q;
endmodule

// File: rtl/bintc_resolve.sv
module bintc_resolve #(
  parameter int N  = 96,
  parameter int PW = 5,
  parameter int CW = 7
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 any,
  output logic [CW-1:0]        idx
);
  logic          found;
  logic [PW-1:0] best;
  logic [CW-1:0] pick;

  // ascending scan with <= : equal priority resolves to the higher line
  always_comb begin
    found = 1'b0;
    best  = '0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prio[i] <= best)) begin
        found = 1'b1;
        best  = prio[i];
        pick  = CW'(i);
      end
    end
  end

  assign any = found;
  assign idx = pick;
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import bintc_pkg::*;
#(
  parameter int NUM_BANKS = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0] irq_in,
  input  logic                                wr_en,
  input  logic                                rd_en,
  input  logic [BUS_AW-1:0]                   addr,
  input  logic [31:0]                         wdata,
  output logic [31:0]                         rdata,
  output logic                                out_norm,
  output logic                                out_fast
);
  localparam int LB        = LINES_PER_BANK;
  localparam int NUM_LINES = NUM_BANKS * LB;
  localparam int CODE_W    = $clog2(NUM_LINES);
  localparam logic [NUM_LINES-1:0] ONE_HOT0 = NUM_LINES'(1);

  // ---------------- address decode ----------------
  logic [1:0] bsel;
  logic [7:0] off, cfg_off;
  logic       bank_ok, word_ok, glob, is_cfg;
  logic [4:0] cfg_idx;

  assign bsel    = addr[9:8];
  assign off     = addr[7:0];
  assign bank_ok = int'(bsel) < NUM_BANKS;
  assign word_ok = (off[1:0] == 2'b00);
  assign glob    = bank_ok && (bsel == 2'd0) && word_ok;
  assign is_cfg  = word_ok && (off >= OFF_CFG_LO) && (off <= OFF_CFG_HI);
  assign cfg_off = off - OFF_CFG_LO;
  assign cfg_idx = cfg_off[6:2];

  // ---------------- synchroniser ----------------
  logic [NUM_LINES-1:0] all_sync, all_rise, all_fall;

  bintc_sync #(.W(NUM_LINES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (irq_in),
    .sync (all_sync),
    .rise (all_rise),
    .fall (all_fall)
  );

  // ---------------- banks ----------------
  logic [MAX_BANKS-1:0][LB-1:0]    pend_b, mask_b;
  line_cfg_t [LB-1:0]              cfg_b [MAX_BANKS];
  logic [NUM_LINES-1:0]            all_pend, all_mask, all_lvl, all_fast, ack_all;
  logic [NUM_LINES-1:0][PRIO_W-1:0] all_prio;

  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_on
      logic sel;
      assign sel = wr_en && bank_ok && word_ok && (bsel == 2'(b));

      bintc_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (all_sync[b*LB +: LB]),
        .rise    (all_rise[b*LB +: LB]),
        .fall    (all_fall[b*LB +: LB]),
        .pend_wr (sel && off == OFF_PEND),
        .mask_wr (sel && off == OFF_MASK),
        .swset_wr(sel && off == OFF_SWSET),
        .cfg_wr  (sel && is_cfg),
        .cfg_idx (cfg_idx),
        .wdata   (wdata),
        .ack     (ack_all[b*LB +: LB]),
        .pend_o  (pend_b[b]),
        .mask_o  (mask_b[b]),
        .lvl_o   (all_lvl[b*LB +: LB]),
        .fast_o  (all_fast[b*LB +: LB]),
        .cfg_o   (cfg_b[b])
      );

      assign all_pend[b*LB +: LB] = pend_b[b];
      assign all_mask[b*LB +: LB] = mask_b[b];
      for (genvar i = 0; i < LB; i++) begin : g_prio
        assign all_prio[b*LB + i] = cfg_b[b][i].prio;
      end
    end else begin : g_off
      assign pend_b[b] = '0;
      assign mask_b[b] = '0;
      assign cfg_b[b]  = '0;
    end
  end

  // ---------------- resolution and agreement ----------------
  logic [1:0][NUM_LINES-1:0] cand;
  logic [1:0]                out_q, any_k, rd_code;
  logic [1:0][CODE_W-1:0]    win, code_q;
  logic                      ctl_wr;

  assign cand[0] = all_pend & ~all_mask & ~all_fast;
  assign cand[1] = all_pend & ~all_mask &  all_fast;
  assign ctl_wr  = wr_en && glob && (off == OFF_CTRL);

  for (genvar k = 0; k < 2; k++) begin : g_agr
    logic              o_q, armed_q;
    logic [CODE_W-1:0] c_q;

    bintc_resolve #(.N(NUM_LINES), .PW(PRIO_W), .CW(CODE_W)) u_res (
      .cand(cand[k]),
      .prio(all_prio),
      .any (any_k[k]),
      .idx (win[k])
    );

    assign rd_code[k] = rd_en && glob && (off == ((k == 0) ? OFF_CODE_N : OFF_CODE_F));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        o_q     <= 1'b0;
        armed_q <= 1'b1;
        c_q     <= '0;
      end else if (ctl_wr && wdata[k]) begin
        o_q     <= 1'b0;
        armed_q <= 1'b1;
      end else if (armed_q && any_k[k]) begin
        o_q     <= 1'b1;
        armed_q <= 1'b0;
        c_q     <= win[k];
      end
    end

    assign out_q[k]  = o_q;
    assign code_q[k] = c_q;
  end

  // a code read acknowledges the captured line (banks spare level lines)
  always_comb begin
    ack_all = '0;
    for (int k = 0; k < 2; k++)
      if (rd_code[k]) ack_all = ack_all | (ONE_HOT0 << code_q[k]);
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata = '0;
    if (rd_en && bank_ok && word_ok) begin
      if (off == OFF_PEND)                   rdata = pend_b[bsel];
      else if (off == OFF_MASK)              rdata = mask_b[bsel];
      else if (glob && off == OFF_CODE_N)    rdata = 32'(code_q[0]);
      else if (glob && off == OFF_CODE_F)    rdata = 32'(code_q[1]);
      else if (is_cfg)                       rdata = 32'(cfg_b[bsel][cfg_idx]);
    end
  end

  assign out_norm = out_q[0];
  assign out_fast = out_q[1];
endmodule

// File: rtl/bintc_chk.sv
module bintc_chk #(
  parameter int N = 96
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   out_q,
  input logic [1:0]   any_k,
  input logic         ctl_wr,
  input logic [1:0]   ctl_bits,
  input logic [N-1:0] lvl,
  input logic [N-1:0] sync,
  input logic [N-1:0] pend
);
  // R8
  norm_rise_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q[0]) |-> $past(any_k[0]));

  // R8
  fast_rise_needs_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q[1]) |-> $past(any_k[1]));

  // R8
  norm_rearm_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_bits[0]) |=> !out_q[0]);

  // R8
  fast_rearm_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_bits[1]) |=> !out_q[1]);

  // R8
  norm_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q[0] && !(ctl_wr && ctl_bits[0])) |=> out_q[0]);

  // R8
  fast_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q[1] && !(ctl_wr && ctl_bits[1])) |=> out_q[1]);

  // R4
  level_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q[0] || !out_q[0]) |=> ((lvl & sync & ~pend) == '0 || (($past(lvl & sync) & ~pend) == '0)));
endmodule

bind banked_intc bintc_chk #(.N(NUM_LINES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .out_q   (out_q),
  .any_k   (any_k),
  .ctl_wr  (ctl_wr),
  .ctl_bits(wdata[1:0]),
  .lvl     (all_lvl),
  .sync    (all_sync),
  .pend    (all_pend)
);

// File: tb/banked_intc_test.sv
`timescale 1ns/1ps
module banked_intc_test;
  localparam int NB = 3;
  localparam int NL = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          out_norm, out_fast;
  int            checks = 0;
  int            errs = 0;
  logic [31:0]   v;

  always #5 clk = ~clk;

  banked_intc #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .out_norm(out_norm), .out_fast(out_fast)
  );

  function automatic logic [9:0] ra(input int b, input logic [7:0] o);
    return {2'(b), o};
  endfunction

  function automatic logic [7:0] cfgo(input int n);
    return 8'h1C + 8'(4 * n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    irq_in = '0;
    idle(5);
    for (int b = 0; b < NB; b++) begin
      for (int n = 0; n < 32; n++) wr(ra(b, cfgo(n)), 32'h0);
      wr(ra(b, 8'h04), 32'hFFFF_FFFF);
      wr(ra(b, 8'h00), 32'h0);
    end
    wr(ra(0, 8'h18), 32'h3);
    idle(2);
  endtask

  task automatic t_reset();
    chk("R1 out_norm", 32'(out_norm), 32'h0);
    chk("R1 out_fast", 32'(out_fast), 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, 8'h04), v); chk("R1 mask", v, 32'hFFFF_FFFF);
      rd(ra(b, 8'h00), v); chk("R1 pend", v, 32'h0);
    end
    rd(ra(0, cfgo(0)), v); chk("R1 cfg", v, 32'h0);
  endtask

  task automatic t_cfg();
    wr(ra(0, cfgo(31)), 32'h7F); rd(ra(0, cfgo(31)), v); chk("R2 cfg31", v, 32'h7F);
    wr(ra(0, cfgo(1)), 32'hFFFF_FFFF); rd(ra(0, cfgo(1)), v); chk("R2 upper dropped", v, 32'h7F);
    wr(ra(2, cfgo(4)), 32'h55); rd(ra(2, cfgo(4)), v); chk("R2 bank2 cfg", v, 32'h55);
  endtask

  task automatic t_latency();
    clean();
    wr(ra(0, 8'h04), ~32'(1 << 5));
    irq_in[5] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R12 still low after 3 edges", 32'(out_norm), 32'h0);
    @(negedge clk); chk("R12 high after 4 edges", 32'(out_norm), 32'h1);
    rd(ra(0, 8'h10), v); chk("R9 code line 5", v, 32'd5);
  endtask

  task automatic t_edge();
    clean();
    wr(ra(0, 8'h04), ~32'(1 << 3));
    irq_in[3] = 1'b1;
    idle(6);
    rd(ra(0, 8'h00), v); chk("R3 edge pending", v, 32'h8);
    rd(ra(0, 8'h10), v); chk("R9 code line 3", v, 32'd3);
    rd(ra(0, 8'h00), v); chk("R3 held input not repended", v, 32'h0);
    irq_in[3] = 1'b0; idle(5);
    rd(ra(0, 8'h00), v); chk("R3 fall no pend", v, 32'h0);
    irq_in[3] = 1'b1; idle(5);
    rd(ra(0, 8'h00), v); chk("R3 new rise pends", v, 32'h8);
  endtask

  task automatic t_level();
    clean();
    wr(ra(0, cfgo(7)), 32'h2);
    wr(ra(0, 8'h04), ~32'(1 << 7));
    irq_in[7] = 1'b1;
    idle(6);
    rd(ra(0, 8'h00), v); chk("R4 level pending", v, 32'h80);
    wr(ra(0, 8'h00), 32'h0);
    rd(ra(0, 8'h00), v); chk("R4 clear write ignored", v, 32'h80);
    rd(ra(0, 8'h10), v); chk("R9 code line 7", v, 32'd7);
    rd(ra(0, 8'h00), v); chk("R9 level not acked", v, 32'h80);
    irq_in[7] = 1'b0; idle(5);
    rd(ra(0, 8'h00), v); chk("R4 fall clears", v, 32'h0);
  endtask

  task automatic t_pendwr();
    clean();
    wr(ra(1, 8'h08), 32'hF0);
    rd(ra(1, 8'h00), v); chk("R6 swset bank1", v, 32'hF0);
    wr(ra(1, 8'h00), 32'h30);
    rd(ra(1, 8'h00), v); chk("R5 AND write", v, 32'h30);
  endtask

  task automatic t_agree();
    clean();
    wr(ra(0, 8'h04), ~32'h600);
    wr(ra(0, 8'h08), 32'h200);
    idle(2);
    chk("R6 swset raises", 32'(out_norm), 32'h1);
    rd(ra(0, 8'h10), v); chk("R9 code line 9", v, 32'd9);
    idle(3); chk("R8 stays high", 32'(out_norm), 32'h1);
    wr(ra(0, 8'h08), 32'h400);
    idle(3);
    rd(ra(0, 8'h10), v); chk("R8 code fixed", v, 32'd9);
    wr(ra(0, 8'h18), 32'h1);
    chk("R8 rearm drops", 32'(out_norm), 32'h0);
    idle(1); chk("R8 reraise", 32'(out_norm), 32'h1);
    rd(ra(0, 8'h10), v); chk("R8 new code 10", v, 32'd10);
    wr(ra(0, 8'h18), 32'h1);
    idle(3); chk("R8 no candidate stays low", 32'(out_norm), 32'h0);
  endtask

  task automatic t_prio();
    clean();
    wr(ra(0, cfgo(2)), 32'h10);
    wr(ra(0, cfgo(20)), 32'h04);
    wr(ra(1, cfgo(8)), 32'h04);
    wr(ra(0, 8'h08), 32'h0010_0004);
    wr(ra(1, 8'h08), 32'h100);
    wr(ra(0, 8'h04), ~32'h0010_0004);
    wr(ra(1, 8'h04), ~32'h100);
    wr(ra(0, 8'h18), 32'h3); idle(2);
    rd(ra(0, 8'h10), v); chk("R7 tie higher line", v, 32'd40);
    wr(ra(0, 8'h18), 32'h1); idle(2);
    rd(ra(0, 8'h10), v); chk("R7 next prio", v, 32'd20);
    wr(ra(0, 8'h18), 32'h1); idle(2);
    rd(ra(0, 8'h10), v); chk("R7 lowest prio last", v, 32'd2);
    wr(ra(0, cfgo(2)), 32'h11);
    wr(ra(0, 8'h08), 32'h4);
    wr(ra(0, 8'h18), 32'h3); idle(2);
    chk("R7 fast routed", 32'(out_fast), 32'h1);
    chk("R7 normal not raised", 32'(out_norm), 32'h0);
    rd(ra(0, 8'h14), v); chk("R9 fast code", v, 32'd2);
  endtask

  task automatic t_mask();
    clean();
    wr(ra(0, 8'h08), 32'h1000);
    idle(3); chk("R10 masked no raise", 32'(out_norm), 32'h0);
    wr(ra(0, 8'h04), ~32'h1000);
    idle(2); chk("R10 unmask raises", 32'(out_norm), 32'h1);
    rd(ra(0, 8'h04), v); chk("R10 mask readback", v, 32'hFFFF_EFFF);
    rd(ra(0, 8'h10), v); chk("R10 code 12", v, 32'd12);
  endtask

  task automatic t_bank();
    clean();
    wr(ra(2, 8'h04), 32'h1234);
    rd(ra(2, 8'h04), v); chk("R11 bank2 mask", v, 32'h1234);
    rd(ra(1, 8'h04), v); chk("R11 bank1 untouched", v, 32'hFFFF_FFFF);
    wr(ra(3, 8'h04), 32'h0);
    rd(ra(3, 8'h04), v); chk("R11 bank3 reads zero", v, 32'h0);
    rd(ra(0, 8'h04), v); chk("R11 bank0 untouched", v, 32'hFFFF_FFFF);
    rd(ra(0, 8'h0C), v); chk("R11 unused offset", v, 32'h0);
    rd(ra(0, 8'h05), v); chk("R11 misaligned", v, 32'h0);
    wr(ra(0, 8'h08), 32'h1);
    rd(ra(1, 8'h00), v); chk("R11 swset bank0 only", v, 32'h0);
    rd(ra(1, 8'h10), v); chk("R11 code outside bank0", v, 32'h0);
  endtask

  initial begin
    #2_000_000;
    checks++; errs++;
    $display("FAIL watchdog all requirements act hung exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_latency();
    t_edge();
    t_level();
    t_pendwr();
    t_agree();
    t_prio();
    t_mask();
    t_bank();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule